// File: doc/BRIEF.md
# Delay-Line Lock Controller

This block is the digital tuning engine of a delay-locked loop. It owns the 24-bit control word of a coarse/fine digitally controlled delay line. It steers that word until the line's total delay matches one period of the reference clock. It observes three quantities produced outside it: a phase-detector decision (the delayed clock is early or late), a time-to-digital count of the reference period, and a time-to-digital count of the remaining phase error. It produces the control word and a lock flag.

Tuning runs in steps. The controller first seeds the word from the measured period, using a programmable ratio that converts time-to-digital counts into control code. This places the starting delay close to one period, which rules out locking onto zero delay or onto a multiple of the period. In the coarse stage, a large error is corrected in one jump through the same ratio, and a moderate error moves the coarse field one step. A small error starts a binary search over the fine range. The search is followed by single fine steps. A steady alternation of early/late decisions declares lock and freezes the word. A large error at any later point sends the controller back to coarse tuning.

The reference clock is asynchronous to the controller clock. Its rising edges are brought into the controller domain and counted. Every decision waits for two reference edges after the previous update, so the delay line and the detector have settled before the next sample is taken.

Top module: `dll_lock_ctrl`

## Requirements
- R1: While reset is asserted, `code_o` is 0 and `locked_o` is 0.
- R2: The word packs fields from the top: coarse C1 in bits 23:17, coarse C2 in 16:12, fine F1 in 11:8, F2 in 7:4 and F3 in 3:0. Together they form one linear code in which one coarse unit is 4096 (bit 12) and the fine range is bits 11:0.
- R3: Each decision is taken at the second synchronised rising edge of `ref_clk_i` after reset or after the previous decision. It is visible on `code_o` one controller cycle later. The word changes at no other time.
- R4: The first decision after reset loads `code_o = min(floor(period_cnt_i * ratio_i / 16), 2^24-1)`. `ratio_i` carries 4 fractional bits.
- R5: In coarse tuning, an error count below 10 starts the fine search. The word moves by 2048 in the decision's direction, and the next search step is 1024.
- R6: In coarse tuning, an error count above 80 moves the word by `floor(err_cnt_i * ratio_i / 16)`. The move is upward when `lead_i` is 1.
- R7: In coarse tuning, an error count from 10 to 80 moves the word by one coarse unit (4096). The move is upward when `lead_i` is 1 (delayed clock early) and downward when it is 0.
- R8: During the search, each decision moves the word by the current step, and the step then halves. The step after 1 is single fine steps of 1 per decision.
- R9: In single-step tuning, eight consecutive decisions lead, lag, lead, lag, lead, lag, lead, lag set `locked_o`. The completing decision leaves the word unchanged, and the word then holds.
- R10: An error count above 10 during the search, single-step tuning or lock clears `locked_o`. The same decision applies the coarse rule of R6 or R7.
- R11: Every move saturates: the word never wraps below 0 or above 2^24-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock, asynchronous to `clk` |
| lead_i | input | 1 | Phase decision: 1 = delayed clock early (add delay), 0 = late |
| period_cnt_i | input | 16 | Time-to-digital count of one reference period |
| err_cnt_i | input | 16 | Time-to-digital count of the residual phase error |
| ratio_i | input | 20 | Code per count, 4 fractional bits |
| code_o | output | 24 | Delay-line control word |
| locked_o | output | 1 | Lock flag |

## Verification
The hardest states to reach from the ports are the two saturation corners and the exit from lock. Reaching them needs a delay target that the word cannot represent, or a target that moves after lock. The bench closes the loop through an ideal delay line, detector and converter whose target it sets per run. A target above the largest code and a target of zero pin the word at its two rails. A target shift of 30000 code units after lock forces the large-error exit. A per-cycle arithmetic model of the tuning rules is compared against `code_o` and `locked_o` on every cycle, so each remap, coarse step, search step and alternation is checked at the cycle it lands.

// File: rtl/dll_lock_pkg.sv
package dll_lock_pkg;
  localparam int CODE_W = 24;
  // fine fields occupy bits 11:0, coarse fields start at bit 12
  localparam int FINE_W = 12;
  localparam logic [CODE_W-1:0] CODE_MAX    = '1;
  localparam logic [CODE_W-1:0] COARSE_UNIT = CODE_W'(1) << FINE_W;
  localparam logic [CODE_W-1:0] SEARCH_SPAN = CODE_W'(1) << (FINE_W - 1);

  typedef enum logic [2:0] {
    M_MAP    = 3'd0,
    M_COARSE = 3'd1,
    M_SEARCH = 3'd2,
    M_FINE   = 3'd3,
    M_LOCK   = 3'd4
  } tune_mode_e;

  function automatic logic [CODE_W-1:0] code_plus(logic [CODE_W-1:0] c,
                                                  logic [CODE_W-1:0] d);
    logic [CODE_W:0] s;
    s = {1'b0, c} + {1'b0, d};
    return s[CODE_W] ? CODE_MAX : s[CODE_W-1:0];
  endfunction

  function automatic logic [CODE_W-1:0] code_minus(logic [CODE_W-1:0] c,
                                                   logic [CODE_W-1:0] d);
    return (d > c) ? '0 : (c - d);
  endfunction

  function automatic logic [CODE_W-1:0] code_clip(logic [63:0] v);
    return (v > 64'(CODE_MAX)) ? CODE_MAX : v[CODE_W-1:0];
  endfunction
endpackage

// File: rtl/dll_ref_sync.sv
module dll_ref_sync #(
  parameter int EDGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_clk_i,
  output logic fire_o
);
  localparam int CW = $clog2(EDGES + 1);

  logic [2:0]    pipe_q;
  logic [CW-1:0] cnt_q;
  logic          rise;

  // two synchronising flops, a third for the edge detector
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[1:0], ref_clk_i};
  end

  assign rise   = pipe_q[1] & ~pipe_q[2];
  assign fire_o = rise && (cnt_q == CW'(EDGES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (fire_o) cnt_q <= '0;
    else if (rise)   cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/dll_step_cand.sv
module dll_step_cand
  import dll_lock_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CODE_W-1:0]      code_i,
  input  logic [CODE_W-1:0]      step_i,
  output logic [2:0][CODE_W-1:0] up_o,
  output logic [2:0][CODE_W-1:0] dn_o
);
  // slot 0: coarse unit, slot 1: search entry span, slot 2: current step
  logic [2:0][CODE_W-1:0] unit_w;
  assign unit_w[0] = COARSE_UNIT;
  assign unit_w[1] = SEARCH_SPAN;
  assign unit_w[2] = step_i;

  for (genvar k = 0; k < 3; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        up_o[k] <= '0;
        dn_o[k] <= '0;
      end else begin
        up_o[k] <= code_plus(code_i, unit_w[k]);
        dn_o[k] <= code_minus(code_i, unit_w[k]);
      end
    end
  end
endmodule

// File: rtl/dll_alt_run.sv
module dll_alt_run #(
  parameter int PAIRS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic valid_i,
  input  logic lead_i,
  output logic done_o
);
  localparam int RUN = 2 * PAIRS;
  localparam int CW  = $clog2(RUN + 1);

  logic [CW-1:0] n_q;
  logic          want_lead;
  logic          match;

  assign want_lead = ~n_q[0];
  assign match     = (lead_i == want_lead);
  assign done_o    = valid_i && match && (n_q == CW'(RUN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       n_q <= '0;
    else if (clear_i) n_q <= '0;
    else if (valid_i) begin
      if (!match)      n_q <= lead_i ? CW'(1) : '0;
      else if (done_o) n_q <= '0;
      else             n_q <= n_q + CW'(1);
    end
  end
endmodule

// File: rtl/dll_lock_ctrl.sv
module dll_lock_ctrl
  import dll_lock_pkg::*;
#(
  parameter int TDC_W      = 16,
  parameter int RATIO_W    = 20,
  parameter int RATIO_FRAC = 4,
  parameter int FINE_TH    = 10,
  parameter int REMAP_TH   = 80,
  parameter int LOCK_PAIRS = 4,
  parameter int WAIT_EDGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_clk_i,
  input  logic               lead_i,
  input  logic [TDC_W-1:0]   period_cnt_i,
  input  logic [TDC_W-1:0]   err_cnt_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [CODE_W-1:0]  code_o,
  output logic               locked_o
);
  localparam int PROD_W = TDC_W + RATIO_W;

  function automatic logic [CODE_W-1:0] tdc_to_code(logic [TDC_W-1:0] n,
                                                    logic [RATIO_W-1:0] r);
    logic [PROD_W-1:0] p;
    p = PROD_W'(n) * PROD_W'(r);
    return code_clip(64'(p >> RATIO_FRAC));
  endfunction

  tune_mode_e        mode_q, mode_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [CODE_W-1:0] step_q, step_d;
  logic              locked_q, locked_d;

  // named events, also observed by the checker
  logic fire, move_up, move_dn, in_fine, enter_fine, run_done, run_clear, run_valid;
  logic coarse_act, tune_write;
  logic err_low, err_high, err_big;
  logic [2:0][CODE_W-1:0] cand_up, cand_dn;
  logic [CODE_W-1:0] corr, remap_code, coarse_code, entry_code, step_code;

  dll_ref_sync #(.EDGES(WAIT_EDGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk_i), .fire_o(fire)
  );

  dll_step_cand u_cand (
    .clk(clk), .rst_n(rst_n), .code_i(code_q), .step_i(step_q),
    .up_o(cand_up), .dn_o(cand_dn)
  );

  dll_alt_run #(.PAIRS(LOCK_PAIRS)) u_run (
    .clk(clk), .rst_n(rst_n), .clear_i(run_clear), .valid_i(run_valid),
    .lead_i(lead_i), .done_o(run_done)
  );

  assign err_low  = err_cnt_i < TDC_W'(FINE_TH);
  assign err_high = err_cnt_i > TDC_W'(FINE_TH);
  assign err_big  = err_cnt_i > TDC_W'(REMAP_TH);
  assign in_fine  = (mode_q == M_FINE);

  assign corr        = tdc_to_code(err_cnt_i, ratio_i);
  assign remap_code  = lead_i ? code_plus(code_q, corr) : code_minus(code_q, corr);
  assign coarse_code = lead_i ? cand_up[0] : cand_dn[0];
  assign entry_code  = lead_i ? cand_up[1] : cand_dn[1];
  assign step_code   = lead_i ? cand_up[2] : cand_dn[2];

  assign run_valid = fire && in_fine && !err_high;
  assign run_clear = fire && (mode_q == M_SEARCH) && !err_high && (step_q == CODE_W'(1));

  always_comb begin
    mode_d     = mode_q;
    code_d     = code_q;
    step_d     = step_q;
    locked_d   = locked_q;
    coarse_act = 1'b0;
    enter_fine = 1'b0;
    tune_write = 1'b0;
    if (fire) begin
      unique case (mode_q)
        M_MAP: begin
          code_d = tdc_to_code(period_cnt_i, ratio_i);
          mode_d = M_COARSE;
        end
        M_COARSE: coarse_act = 1'b1;
        M_SEARCH: begin
          if (err_high) coarse_act = 1'b1;
          else begin
            tune_write = 1'b1;
            code_d     = step_code;
            if (step_q == CODE_W'(1)) mode_d = M_FINE;
            else                      step_d = step_q >> 1;
          end
        end
        M_FINE: begin
          if (err_high) coarse_act = 1'b1;
          else if (run_done) begin
            mode_d   = M_LOCK;
            locked_d = 1'b1;
          end else begin
            tune_write = 1'b1;
            code_d     = step_code;
          end
        end
        M_LOCK: begin
          if (err_high) coarse_act = 1'b1;
        end
        default: mode_d = M_MAP;
      endcase
    end
    if (coarse_act) begin
      tune_write = 1'b1;
      locked_d   = 1'b0;
      if (err_low) begin
        enter_fine = 1'b1;
        code_d     = entry_code;
        step_d     = SEARCH_SPAN >> 1;
        mode_d     = M_SEARCH;
      end else begin
        mode_d = M_COARSE;
        code_d = err_big ? remap_code : coarse_code;
      end
    end
  end

  assign move_up = tune_write && lead_i;
  assign move_dn = tune_write && !lead_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_MAP;
      code_q   <= '0;
      step_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      code_q   <= code_d;
      step_q   <= step_d;
      locked_q <= locked_d;
    end
  end

  assign code_o   = code_q;
  assign locked_o = locked_q;
endmodule

// File: rtl/dll_lock_ctrl_chk.sv
module dll_lock_ctrl_chk
  import dll_lock_pkg::*;
#(
  parameter int TDC_W   = 16,
  parameter int FINE_TH = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fire,
  input logic              move_up,
  input logic              move_dn,
  input logic              in_fine,
  input logic              locked,
  input logic [TDC_W-1:0]  err,
  input logic [CODE_W-1:0] code
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_reset_r1: assert (code == '0 && !locked);
    end
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(code));

  // R6 and R7: early phase adds delay
  p_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    move_up |=> code >= $past(code));

  p_dn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    move_dn |=> code <= $past(code));

  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(code));

  p_lock_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(in_fine));

  p_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && locked && (err > TDC_W'(FINE_TH))) |=> !locked);
endmodule

bind dll_lock_ctrl dll_lock_ctrl_chk #(.TDC_W(TDC_W), .FINE_TH(FINE_TH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fire(fire), .move_up(move_up), .move_dn(move_dn),
  .in_fine(in_fine), .locked(locked_o), .err(err_cnt_i), .code(code_o)
);

// File: tb/tb_dll_lock_ctrl.sv
`timescale 1ns/100ps
module tb_dll_lock_ctrl;
  localparam longint CMAX = 64'd16777215;
  localparam longint UNITS_PER_COUNT = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        ref_clk = 1'b0;
  logic        lead;
  logic [15:0] per_c, err_c;
  logic [19:0] ratio_c;
  logic [23:0] code_o;
  logic        locked_o;

  longint T = 0;
  longint RATIO = 4096;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  dll_lock_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .lead_i(lead),
    .period_cnt_i(per_c), .err_cnt_i(err_c), .ratio_i(ratio_c),
    .code_o(code_o), .locked_o(locked_o)
  );

  always #2.5 clk = ~clk;
  initial begin
    #1.3;
    forever #401 ref_clk = ~ref_clk;
  end

  function automatic longint clip16(longint v);
    return (v > 65535) ? 65535 : v;
  endfunction
  function automatic longint sat(longint v);
    return (v < 0) ? 0 : ((v > CMAX) ? CMAX : v);
  endfunction
  function automatic longint err_of(longint c);
    longint d;
    d = (c > T) ? c - T : T - c;
    return clip16(d / UNITS_PER_COUNT);
  endfunction

  // ideal delay line + phase detector + time-to-digital converter
  always_comb begin
    lead    = (longint'(code_o) < T);
    err_c   = 16'(err_of(longint'(code_o)));
    per_c   = 16'(clip16(T / UNITS_PER_COUNT));
    ratio_c = 20'(RATIO);
  end

  // arithmetic model of the tuning rules
  logic [2:0] b_pipe;
  int     b_cnt;
  longint m_code, m_step;
  int     m_mode, m_run;
  bit     m_locked;
  string  m_tag = "R1";

  task automatic coarse_rule(input longint c0, input longint e, input bit ld, input string why);
    longint c;
    m_locked <= 1'b0;
    if (e < 10) begin
      c = ld ? c0 + 2048 : c0 - 2048;
      m_step <= 1024; m_mode <= 2; m_tag = {why, "R5"};
    end else if (e > 80) begin
      c = ld ? c0 + (e * RATIO) / 16 : c0 - (e * RATIO) / 16;
      m_mode <= 1; m_tag = {why, "R6"};
    end else begin
      c = ld ? c0 + 4096 : c0 - 4096;
      m_mode <= 1; m_tag = {why, "R7 R2"};
    end
    m_code <= sat(c);
  endtask

  task automatic decide();
    longint c, e;
    bit ld, want;
    c = m_code; ld = (c < T); e = err_of(c);
    case (m_mode)
      0: begin
        m_code <= sat((clip16(T / UNITS_PER_COUNT) * RATIO) / 16);
        m_mode <= 1; m_tag = "R4";
      end
      1: coarse_rule(c, e, ld, "");
      2: begin
        if (e > 10) coarse_rule(c, e, ld, "R10 ");
        else begin
          m_code <= sat(ld ? c + m_step : c - m_step);
          if (m_step == 1) begin m_mode <= 3; m_run <= 0; end
          else m_step <= m_step / 2;
          m_tag = "R8";
        end
      end
      3: begin
        if (e > 10) coarse_rule(c, e, ld, "R10 ");
        else begin
          want = (m_run % 2 == 0);
          if (ld == want && m_run == 7) begin
            m_mode <= 4; m_locked <= 1'b1; m_run <= 0; m_tag = "R9";
          end else begin
            if (ld == want) m_run <= m_run + 1;
            else            m_run <= ld ? 1 : 0;
            m_code <= sat(ld ? c + 1 : c - 1);
            m_tag = "R8 R11";
          end
        end
      end
      default: begin
        if (e > 10) coarse_rule(c, e, ld, "R10 ");
        else m_tag = "R9";
      end
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_pipe <= '0; b_cnt <= 0; m_code <= 0; m_step <= 0;
      m_mode <= 0; m_run <= 0; m_locked <= 1'b0;
    end else begin
      b_pipe <= {b_pipe[1:0], ref_clk};
      if (b_pipe[1] && !b_pipe[2]) begin
        if (b_cnt == 1) begin b_cnt <= 0; decide(); end
        else b_cnt <= b_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // cycle-by-cycle comparison (R3: no change outside a decision)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(longint'(code_o) == m_code, {m_tag, " R3 code"}, longint'(code_o), m_code);
      check(locked_o == m_locked, {m_tag, " R3 lock"}, locked_o, m_locked);
    end
  end

  task automatic start_case(input longint t, input longint r);
    @(negedge clk);
    T = t; RATIO = r;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(code_o == 24'd0, "R1 reset code", code_o, 0);
    check(locked_o == 1'b0, "R1 reset lock", locked_o, 0);
    rst_n = 1'b1;
  endtask

  task automatic expect_lock(input string req);
    longint d;
    d = (longint'(code_o) > T) ? longint'(code_o) - T : T - longint'(code_o);
    check(locked_o == 1'b1, {req, " locked"}, locked_o, 1);
    check(d <= 1, {req, " final distance"}, d, 1);
  endtask

  initial begin
    // nominal: exact ratio, seeded close to target (R4, R5, R8, R9)
    start_case(1000000, 4096);
    repeat (16000) @(negedge clk);
    expect_lock("R9");
    check((longint'(code_o) >> 12) == T / 4096, "R2 coarse field", longint'(code_o) >> 12, T / 4096);
    check(longint'(code_o[11:0]) == T % 4096, "R2 fine field", code_o[11:0], T % 4096);
    // target moves after lock: large error leaves lock (R10)
    T = 1030000;
    repeat (16000) @(negedge clk);
    expect_lock("R10");
    // ratio too small: remap corrections then coarse step (R6, R7)
    start_case(1000000, 3891);
    repeat (16000) @(negedge clk);
    expect_lock("R6");
    // ratio too large: overshooting remaps in both directions (R6, R7)
    start_case(2000000, 5325);
    repeat (16000) @(negedge clk);
    expect_lock("R7");
    // seed saturates at the top of the range, lock just below it (R4, R11)
    start_case(16777000, 65536);
    repeat (16000) @(negedge clk);
    expect_lock("R11");
    // unreachable target above the range: word pinned at maximum (R11)
    start_case(20000000, 4096);
    repeat (12000) @(negedge clk);
    check(longint'(code_o) == CMAX, "R11 upper rail", code_o, CMAX);
    check(locked_o == 1'b0, "R11 no lock upper", locked_o, 0);
    // zero target: every move is downward, word pinned at zero (R11)
    start_case(0, 4096);
    repeat (12000) @(negedge clk);
    check(code_o == 24'd0, "R11 lower rail", code_o, 0);
    check(locked_o == 1'b0, "R11 no lock lower", locked_o, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule